// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Cache Lookup

This block performs the read lookup of a set-associative first-level data cache whose set index and line offset both lie inside the untranslated page-offset bits of the address. A request brings only those 12 low address bits. The block reads every way of the selected set (tags, valid bits and the addressed 64-bit word) at the clock edge that accepts the request. Translation therefore runs in parallel with the array read. When the physical page number (PPN) later arrives with its strobe, the block compares it against the held tags. One cycle after that it reports a hit with data, a miss with the physical line address, or an alignment error.

Lines are installed through a one-cycle fill port that carries a set number, a 40-bit tag and a full 64-byte line. The block places the line itself. It uses the lowest-numbered invalid way if one exists, and otherwise the victim named by a per-set binary pseudo-LRU tree. Hits and fills both refresh that tree.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset every line is invalid, so any lookup reports a miss. All four response outputs are low until the first response.
- R2: A request takes its set from `req_voff[11:6]` and its word from `req_voff[5:3]`. When `ppn_valid` is high at a clock edge and a request is pending, the response appears on the following cycle, with `rsp_valid` high for exactly that one cycle.
- R3: A `ppn_valid` strobe while no request is pending produces no response.
- R4: A hit is reported when a valid way of the set holds a tag equal to `ppn`. In that case `rsp_data` is word `req_voff[5:3]` of the line, where word k is bits [64k+63:64k] of `fill_line`.
- R5: On a miss, `miss_line_addr` equals `{ppn, req_voff[11:6], 6'b0}`.
- R6: A request with `req_voff[2:0]` not zero is answered with `rsp_err` only, and it changes no replacement state.
- R7: The PPN may arrive any number of cycles after the request. A new request issued before the PPN replaces the pending one.
- R8: A fill goes to the lowest-numbered invalid way of its set.
- R9: A fill into a full set evicts the tree victim. Tree node 1 is the root, node n has children 2n and 2n+1, and leaves 8..15 are ways 0..7. At each node, a stored 0 steers toward the lower child and a 1 toward the upper child. The tree resets to all zeros.
- R10: A hit or a fill to way w rewrites each node on w's path so that it points away from w. Misses and errors leave the tree unchanged.
- R11: While `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_err` is high. While it is low, all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a lookup with the given page offset |
| req_voff | input | 12 | Page-offset bits of the virtual address |
| ppn_valid | input | 1 | Translated page number is present |
| ppn | input | 40 | Physical page number, used as the tag |
| fill_valid | input | 1 | Install a line |
| fill_set | input | 6 | Set to install into |
| fill_tag | input | 40 | Tag of the installed line |
| fill_line | input | 512 | Line contents, word k at bits [64k+63:64k] |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup missed |
| rsp_err | output | 1 | Request was not 8-byte aligned |
| rsp_data | output | 64 | Word read on a hit |
| miss_line_addr | output | 52 | Physical line address of a miss |

## Verification
A wrong valid bit or tag shows up at the next lookup of that set. The response then flips between hit and miss, or `rsp_data` carries a word from the wrong way, one cycle after the PPN strobe. A corrupted replacement tree stays hidden until a later fill into a full set evicts the wrong line. That error only becomes visible at the following lookup of the line that should have survived. For this reason, the sequences fill sets completely, touch chosen lines and then probe every tag, and a reference model of the tree follows every hit and fill.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int unsigned DEF_PPN_W  = 40;
  localparam int unsigned DEF_IDX_W  = 6;
  localparam int unsigned DEF_OFF_W  = 6;
  localparam int unsigned DEF_WAYS   = 8;
  localparam int unsigned DEF_WORD_W = 64;

  typedef enum logic [1:0] {
    RK_HIT  = 2'd0,
    RK_MISS = 2'd1,
    RK_ERR  = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/vipt_way_store.sv
module vipt_way_store #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned TAG_W  = 40,
  parameter int unsigned LINE_W = 512,
  parameter int unsigned WORD_W = 64,
  parameter int unsigned WSEL_W = 3
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_wsel,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [WORD_W-1:0] rd_word
);
  localparam int unsigned SETS = 1 << IDX_W;
  localparam int unsigned WB_W = $clog2(WORD_W);

  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [LINE_W-1:0] line_mem [SETS];

  // read-first synchronous arrays, one per way
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      line_mem[wr_idx] <= wr_line;
    end
    if (rd_en) begin
      rd_tag  <= tag_mem[rd_idx];
      rd_word <= line_mem[rd_idx][{rd_wsel, {WB_W{1'b0}}} +: WORD_W];
    end
  end
endmodule

// File: rtl/vipt_plru_pick.sv
module vipt_plru_pick #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned WAY_W = 3
) (
  input  logic [WAYS-2:0]  state_i,
  output logic [WAY_W-1:0] victim_o
);
  // walk from the root: 0 steers low, 1 steers high
  always_comb begin
    int unsigned nd;
    nd = 1;
    for (int d = 0; d < WAY_W; d++) begin
      nd = 2 * nd + 32'(state_i[nd-1]);
    end
    victim_o = WAY_W'(nd - WAYS);
  end
endmodule

// File: rtl/vipt_plru_touch.sv
module vipt_plru_touch #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned WAY_W = 3
) (
  input  logic [WAYS-2:0]  state_i,
  input  logic [WAY_W-1:0] way_i,
  output logic [WAYS-2:0]  state_o
);
  logic [WAY_W:0] leaf;
  assign leaf = {1'b1, way_i};

  for (genvar n = 1; n < WAYS; n++) begin : g_node
    localparam int unsigned DEPTH = $clog2(n + 1) - 1;
    localparam int unsigned SH    = WAY_W - DEPTH;
    logic on_path;
    assign on_path = ((leaf >> SH) == (WAY_W + 1)'(n));
    assign state_o[n-1] = on_path ? ~way_i[SH-1] : state_i[n-1];
  end
endmodule

// File: rtl/vipt_match.sv
module vipt_match #(
  parameter int unsigned WAYS   = 8,
  parameter int unsigned WAY_W  = 3,
  parameter int unsigned TAG_W  = 40,
  parameter int unsigned WORD_W = 64
) (
  input  logic [WAYS-1:0]             way_vld_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
  input  logic [WAYS-1:0][WORD_W-1:0] words_i,
  input  logic [TAG_W-1:0]            ptag_i,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            hit_way_o,
  output logic [WORD_W-1:0]           word_o
);
  logic [WAYS-1:0] eq;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign eq[g] = way_vld_i[g] && (tags_i[g] == ptag_i);
  end

  assign hit_o = |eq;

  always_comb begin
    hit_way_o = '0;
    word_o    = '0;
    for (int g = 0; g < WAYS; g++) begin
      if (eq[g]) hit_way_o = WAY_W'(g);
      word_o = word_o | (words_i[g] & {WORD_W{eq[g]}});
    end
  end
endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup
  import vipt_pkg::*;
#(
  parameter int unsigned PPN_W  = DEF_PPN_W,
  parameter int unsigned IDX_W  = DEF_IDX_W,
  parameter int unsigned OFF_W  = DEF_OFF_W,
  parameter int unsigned WAYS   = DEF_WAYS,
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  input  logic [IDX_W+OFF_W-1:0]         req_voff,
  input  logic                           ppn_valid,
  input  logic [PPN_W-1:0]               ppn,
  input  logic                           fill_valid,
  input  logic [IDX_W-1:0]               fill_set,
  input  logic [PPN_W-1:0]               fill_tag,
  input  logic [(8<<OFF_W)-1:0]          fill_line,
  output logic                           rsp_valid,
  output logic                           rsp_hit,
  output logic                           rsp_miss,
  output logic                           rsp_err,
  output logic [WORD_W-1:0]              rsp_data,
  output logic [PPN_W+IDX_W+OFF_W-1:0]   miss_line_addr
);
  localparam int unsigned PGOFF_W = IDX_W + OFF_W;
  localparam int unsigned SETS    = 1 << IDX_W;
  localparam int unsigned LINE_W  = 8 << OFF_W;
  localparam int unsigned BSEL_W  = $clog2(WORD_W / 8);
  localparam int unsigned WSEL_W  = OFF_W - BSEL_W;
  localparam int unsigned WAY_W   = $clog2(WAYS);

  // per-set state held in flops (resettable)
  logic [WAYS-1:0] vld_q  [SETS];
  logic [WAYS-2:0] plru_q [SETS];

  // pending request captured with the array read
  logic              pend_q;
  logic [IDX_W-1:0]  pend_idx_q;
  logic              pend_err_q;
  logic [WAYS-1:0]   snap_vld_q;

  logic [WAYS-1:0][PPN_W-1:0]  rd_tags;
  logic [WAYS-1:0][WORD_W-1:0] rd_words;

  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_wsel;
  logic              req_misal;
  assign req_idx   = req_voff[PGOFF_W-1:OFF_W];
  assign req_wsel  = req_voff[OFF_W-1:BSEL_W];
  assign req_misal = |req_voff[BSEL_W-1:0];

  // ---------------- fill way choice ----------------
  logic [WAYS-1:0]  fill_row;
  logic             fill_has_inv;
  logic [WAY_W-1:0] fill_inv_way;
  logic [WAY_W-1:0] fill_tree_way;
  logic [WAY_W-1:0] fill_way;
  logic [WAYS-2:0]  fill_tree_next;

  assign fill_row     = vld_q[fill_set];
  assign fill_has_inv = ~&fill_row;

  always_comb begin
    fill_inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!fill_row[w]) fill_inv_way = WAY_W'(w);
    end
  end

  vipt_plru_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
    .state_i  (plru_q[fill_set]),
    .victim_o (fill_tree_way)
  );

  assign fill_way = fill_has_inv ? fill_inv_way : fill_tree_way;

  vipt_plru_touch #(.WAYS(WAYS), .WAY_W(WAY_W)) u_touch_fill (
    .state_i (plru_q[fill_set]),
    .way_i   (fill_way),
    .state_o (fill_tree_next)
  );

  // ---------------- way arrays ----------------
  for (genvar g = 0; g < WAYS; g++) begin : g_way
    vipt_way_store #(
      .IDX_W  (IDX_W),
      .TAG_W  (PPN_W),
      .LINE_W (LINE_W),
      .WORD_W (WORD_W),
      .WSEL_W (WSEL_W)
    ) u_store (
      .clk     (clk),
      .rd_en   (req_valid),
      .rd_idx  (req_idx),
      .rd_wsel (req_wsel),
      .wr_en   (fill_valid && (fill_way == WAY_W'(g))),
      .wr_idx  (fill_set),
      .wr_tag  (fill_tag),
      .wr_line (fill_line),
      .rd_tag  (rd_tags[g]),
      .rd_word (rd_words[g])
    );
  end

  // ---------------- tag compare ----------------
  logic              m_hit;
  logic [WAY_W-1:0]  m_way;
  logic [WORD_W-1:0] m_word;

  vipt_match #(
    .WAYS   (WAYS),
    .WAY_W  (WAY_W),
    .TAG_W  (PPN_W),
    .WORD_W (WORD_W)
  ) u_match (
    .way_vld_i (snap_vld_q),
    .tags_i    (rd_tags),
    .words_i   (rd_words),
    .ptag_i    (ppn),
    .hit_o     (m_hit),
    .hit_way_o (m_way),
    .word_o    (m_word)
  );

  logic      cmp_fire;
  rsp_kind_e kind;
  logic      hit_upd;
  logic [WAYS-2:0] hit_tree_next;

  assign cmp_fire = ppn_valid && pend_q;

  always_comb begin
    if (pend_err_q)  kind = RK_ERR;
    else if (m_hit)  kind = RK_HIT;
    else             kind = RK_MISS;
  end

  assign hit_upd = cmp_fire && (kind == RK_HIT);

  vipt_plru_touch #(.WAYS(WAYS), .WAY_W(WAY_W)) u_touch_hit (
    .state_i (plru_q[pend_idx_q]),
    .way_i   (m_way),
    .state_o (hit_tree_next)
  );

  // ---------------- state ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        plru_q[s] <= '0;
      end
    end else begin
      if (hit_upd) plru_q[pend_idx_q] <= hit_tree_next;
      if (fill_valid) begin
        plru_q[fill_set]          <= fill_tree_next;
        vld_q[fill_set][fill_way] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      pend_err_q <= 1'b0;
      snap_vld_q <= '0;
    end else if (req_valid) begin
      pend_q     <= 1'b1;
      pend_idx_q <= req_idx;
      pend_err_q <= req_misal;
      snap_vld_q <= vld_q[req_idx];
    end else if (cmp_fire) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_miss       <= 1'b0;
      rsp_err        <= 1'b0;
      rsp_data       <= '0;
      miss_line_addr <= '0;
    end else begin
      rsp_valid <= cmp_fire;
      rsp_hit   <= cmp_fire && (kind == RK_HIT);
      rsp_miss  <= cmp_fire && (kind == RK_MISS);
      rsp_err   <= cmp_fire && (kind == RK_ERR);
      if (cmp_fire) begin
        rsp_data       <= (kind == RK_HIT) ? m_word : '0;
        miss_line_addr <= {ppn, pend_idx_q, {OFF_W{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/vipt_l1_lookup_chk.sv
module vipt_l1_lookup_chk #(
  parameter int unsigned PPN_W  = 40,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned OFF_W  = 6,
  parameter int unsigned BSEL_W = 3
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         req_valid,
  input logic [IDX_W+OFF_W-1:0]       req_voff,
  input logic                         ppn_valid,
  input logic [PPN_W-1:0]             ppn,
  input logic                         rsp_valid,
  input logic                         rsp_hit,
  input logic                         rsp_miss,
  input logic                         rsp_err,
  input logic [PPN_W+IDX_W+OFF_W-1:0] miss_line_addr
);
  localparam int unsigned PGOFF_W = IDX_W + OFF_W;
  localparam int unsigned ADDR_W  = PPN_W + PGOFF_W;

  logic [PGOFF_W-1:0] last_off;
  always_ff @(posedge clk) begin
    if (rst)            last_off <= '0;
    else if (req_valid) last_off <= req_voff;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rsp_valid); // R1
  AST_RSP_AFTER_PPN: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(ppn_valid)); // R2
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_err}) == 1)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_err)); // R11
  AST_MISS_TAG: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_miss) |-> ((miss_line_addr[ADDR_W-1 -: PPN_W] == $past(ppn))
                                 && (miss_line_addr[OFF_W-1:0] == '0))); // R5
  AST_MISS_SET: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_miss) |->
      (miss_line_addr[PGOFF_W-1:OFF_W] == $past(last_off[PGOFF_W-1:OFF_W]))); // R5
  AST_ERR_ALIGN: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_err == ($past(last_off[BSEL_W-1:0]) != '0))); // R6
endmodule

bind vipt_l1_lookup vipt_l1_lookup_chk #(
  .PPN_W  (PPN_W),
  .IDX_W  (IDX_W),
  .OFF_W  (OFF_W),
  .BSEL_W ($clog2(WORD_W / 8))
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_voff       (req_voff),
  .ppn_valid      (ppn_valid),
  .ppn            (ppn),
  .rsp_valid      (rsp_valid),
  .rsp_hit        (rsp_hit),
  .rsp_miss       (rsp_miss),
  .rsp_err        (rsp_err),
  .miss_line_addr (miss_line_addr)
);

// File: tb/vipt_l1_lookup_tb.sv
module vipt_l1_lookup_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSETS = 64;
  localparam int NWAYS = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [11:0]  req_voff = '0;
  logic         ppn_valid = 1'b0;
  logic [39:0]  ppn = '0;
  logic         fill_valid = 1'b0;
  logic [5:0]   fill_set = '0;
  logic [39:0]  fill_tag = '0;
  logic [511:0] fill_line = '0;
  logic         rsp_valid, rsp_hit, rsp_miss, rsp_err;
  logic [63:0]  rsp_data;
  logic [51:0]  miss_line_addr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model
  bit           m_vld  [NSETS][NWAYS];
  logic [39:0]  m_tag  [NSETS][NWAYS];
  logic [511:0] m_line [NSETS][NWAYS];
  logic [6:0]   m_tree [NSETS];

  always #(CLK_PERIOD/2) clk = ~clk;

  vipt_l1_lookup u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_voff(req_voff),
    .ppn_valid(ppn_valid), .ppn(ppn), .fill_valid(fill_valid),
    .fill_set(fill_set), .fill_tag(fill_tag), .fill_line(fill_line),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_err(rsp_err), .rsp_data(rsp_data), .miss_line_addr(miss_line_addr)
  );

  function automatic int b_victim(logic [6:0] st);
    int n = 1;
    for (int d = 0; d < 3; d++) n = 2 * n + int'(st[n-1]);
    return n - 8;
  endfunction

  function automatic logic [6:0] b_touch(logic [6:0] st, int w);
    int n = 1;
    for (int d = 2; d >= 0; d--) begin
      int b = (w >> d) & 1;
      st[n-1] = (b == 0);
      n = 2 * n + b;
    end
    return st;
  endfunction

  function automatic logic [511:0] rand_line();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom();
    return r;
  endfunction

  function automatic logic [39:0] tag_of(int k);
    return 40'h12_3400_0000 + 40'(k) * 40'h0_0101_0011;
  endfunction

  function automatic bit present(int s, logic [39:0] t);
    for (int w = 0; w < NWAYS; w++) if (m_vld[s][w] && m_tag[s][w] == t) return 1;
    return 0;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_fill(int s, logic [39:0] t, logic [511:0] ln);
    int w = -1;
    for (int i = NWAYS - 1; i >= 0; i--) if (!m_vld[s][i]) w = i;
    if (w < 0) w = b_victim(m_tree[s]);
    m_vld[s][w] = 1; m_tag[s][w] = t; m_line[s][w] = ln;
    m_tree[s] = b_touch(m_tree[s], w);
    fill_valid = 1; fill_set = 6'(s); fill_tag = t; fill_line = ln;
    @(negedge clk);
    fill_valid = 0;
  endtask

  // request, wait gap cycles, present PPN, check the response next cycle
  task automatic do_lookup(logic [11:0] off, logic [39:0] p, int gap, string req);
    int s = int'(off[11:6]);
    bit err = (off[2:0] != 3'd0);
    int hw = -1;
    logic [63:0] exp_word;
    for (int w = 0; w < NWAYS; w++) if (m_vld[s][w] && m_tag[s][w] == p) hw = w;
    exp_word = (hw >= 0) ? m_line[s][hw][int'(off[5:3])*64 +: 64] : 64'd0;
    req_valid = 1; req_voff = off;
    @(negedge clk);
    req_valid = 0;
    repeat (gap) @(negedge clk);
    ppn_valid = 1; ppn = p;
    @(negedge clk);
    ppn_valid = 0;
    chk(req, "rsp_valid", 64'(rsp_valid), 64'd1);
    if (err) begin
      chk(req, "err kind", {61'd0, rsp_hit, rsp_miss, rsp_err}, 64'b001);
    end else if (hw >= 0) begin
      chk(req, "hit kind", {61'd0, rsp_hit, rsp_miss, rsp_err}, 64'b100);
      chk(req, "hit data", rsp_data, exp_word);
      m_tree[s] = b_touch(m_tree[s], hw);
    end else begin
      chk(req, "miss kind", {61'd0, rsp_hit, rsp_miss, rsp_err}, 64'b010);
      chk(req, "miss addr", 64'(miss_line_addr), 64'({p, off[11:6], 6'd0}));
    end
    @(negedge clk);
    chk("R11", "pulse one cycle", {60'd0, rsp_valid, rsp_hit, rsp_miss, rsp_err}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20231));
    for (int s = 0; s < NSETS; s++) begin
      m_tree[s] = '0;
      for (int w = 0; w < NWAYS; w++) begin m_vld[s][w] = 0; m_tag[s][w] = '0; m_line[s][w] = '0; end
    end
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1", "outputs after reset", {60'd0, rsp_valid, rsp_hit, rsp_miss, rsp_err}, 64'd0);
    do_lookup({6'h05, 3'd1, 3'd0}, tag_of(1), 0, "R1");

    // R3: strobe with nothing pending
    ppn_valid = 1; ppn = tag_of(2);
    @(negedge clk);
    ppn_valid = 0;
    chk("R3", "no response", 64'(rsp_valid), 64'd0);

    // R4/R2/R7: hit with delayed PPN
    do_fill(13, tag_of(3), rand_line());
    do_lookup({6'h0D, 3'd2, 3'd0}, tag_of(3), 3, "R4");
    do_lookup({6'h0D, 3'd7, 3'd0}, tag_of(3), 0, "R2");
    do_lookup({6'h0D, 3'd2, 3'd0}, tag_of(4), 1, "R5");
    do_lookup({6'h0D, 3'd2, 3'd5}, tag_of(3), 0, "R6");
    // R7: second request replaces the first
    req_valid = 1; req_voff = {6'h0D, 3'd0, 3'd0};
    @(negedge clk);
    do_lookup({6'h07, 3'd4, 3'd0}, tag_of(3), 1, "R7");

    // R8/R9/R10: fill a whole set, touch way 0, then evict
    for (int k = 0; k < 8; k++) do_fill(20, tag_of(10 + k), rand_line());
    for (int k = 0; k < 8; k++) do_lookup({6'd20, 3'(k), 3'd0}, tag_of(10 + k), 0, "R8");
    do_lookup({6'd20, 3'd0, 3'd0}, tag_of(10), 0, "R10");
    do_lookup({6'd20, 3'd0, 3'd0}, tag_of(40), 0, "R10");
    do_lookup({6'd20, 3'd0, 3'd4}, tag_of(11), 0, "R10");
    do_fill(20, tag_of(30), rand_line());
    for (int k = 0; k < 8; k++) do_lookup({6'd20, 3'd3, 3'd0}, tag_of(10 + k), 0, "R9");
    do_lookup({6'd20, 3'd6, 3'd0}, tag_of(30), 0, "R9");

    // random mix
    for (int it = 0; it < 700; it++) begin
      int s = int'($urandom_range(0, 3));
      int k = int'($urandom_range(0, 11));
      if ($urandom_range(0, 9) < 3) begin
        if (!present(s, tag_of(k))) do_fill(s, tag_of(k), rand_line());
      end else begin
        logic [2:0] lo = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
        do_lookup({6'(s), 3'($urandom_range(0, 7)), lo}, tag_of(k),
                  int'($urandom_range(0, 3)), "R9");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule